// File: doc/BRIEF.md
# Alignment-Aware Bus Cycle Sequencer

The sequencer sits between a processor core and its external memory bus. The core hands it one operand access at a time: a size (byte, word or doubleword), a byte address, a read or write flag and, for writes, the data. The sequencer runs as many external bus cycles as the operand's alignment and the data-bus width require. It drives the address, the address strobe, a read or write strobe, byte enables and write data, and for reads it assembles the returned bytes into one operand.

Every bus cycle has a fixed shape: an address state, an optional translation state when the `XLAT` parameter is set, a strobe state, a data state that is repeated while the memory holds its ready line low, and a wind-down state. The next cycle cannot begin until the wind-down state has ended. The core is told that the operand is usable one clock before the wind-down state of the final cycle ends. The data-bus width is set by `BUS_BYTES`, which is 2 or 4.

Top module: `bus_seq`

## Requirements
- R1: During and after reset, and whenever no request is in progress, `busy`, `op_ready`, `bus_as`, `bus_rd` and `bus_wr` are low and `bus_be` is all zeros.
- R2: Each bus cycle runs an address state with `bus_as` high for exactly one clock, then a translation state only when `XLAT` is 1, then a strobe state, a data state and a wind-down state. `bus_rd` (for reads) or `bus_wr` (for writes) is high in the strobe state and in every data state. Neither is high in any other state, and the two are never high together.
- R3: With `BUS_BYTES`=2, a request is split into one bus cycle for each 2-byte bus word it touches. `req_size` encodes 0 as byte, 1 as word, and 2 or 3 as doubleword. So a byte or an even-address word needs 1 cycle, an odd-address word or a doubleword at an even address needs 2, and an odd-address doubleword needs 3.
- R4: With `BUS_BYTES`=4, a request is split into one bus cycle for each 4-byte bus word it touches. So a byte, a word that stays inside a doubleword, or an aligned doubleword needs 1 cycle. A word at offset 3 or an unaligned doubleword needs 2.
- R5: Counting from the first clock in which `busy` is high, `op_ready` rises after cycles × L − 1 clocks, where L is 4, or 5 when `XLAT` is 1. For 1, 2 and 3 cycles this gives 3, 7 and 11 clocks without translation, and 4, 9 and 14 with it. `op_ready` is high for one clock, in the final wind-down state, and `busy` is low in the next clock.
- R6: `bus_ready` is sampled in the data state. While it is low, the data state repeats, and each repeat adds one clock to that cycle and to the latency of R5.
- R7: `bus_addr` is the byte address of the bus word, with its low log2(`BUS_BYTES`) bits zero. Bit j of `bus_be` selects data lane j, bits 8j+7..8j, which carries the byte at `bus_addr`+j. The enables mark exactly the operand bytes inside that bus word. Address and enables hold steady from the address state through the wind-down state.
- R8: For a read, bits 8i+7..8i of `op_rdata` hold the byte from address `req_addr`+i for each byte i of the operand. The bits above the operand size are zero. The value is valid while `op_ready` is high.
- R9: For a write, the byte at `req_addr`+i receives bits 8i+7..8i of `req_wdata` for each byte i of the operand. No other address is written.
- R10: A request is accepted only while `busy` is low. A `req_valid` pulse while busy is high is dropped: it does not change the access in progress, and it does not start an access afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Operand access request, taken when idle |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 doubleword |
| req_addr | input | ADDR_W | Operand byte address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write operand, least significant byte at lowest address |
| bus_ready | input | 1 | Memory ready, sampled in the data state |
| bus_rdata | input | 8×BUS_BYTES | Read data lanes |
| busy | output | 1 | Access in progress |
| op_ready | output | 1 | Operand usable, one-clock pulse |
| op_rdata | output | 32 | Assembled read operand |
| bus_addr | output | ADDR_W | Bus-word address |
| bus_as | output | 1 | Address strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_be | output | BUS_BYTES | Byte lane enables |
| bus_wdata | output | 8×BUS_BYTES | Write data lanes |

## Verification
The assertions assume that `req_valid` is a short pulse. They also assume that `bus_ready`, once it is sampled high in a data state, ends that state. Nothing is assumed about `req_valid` pulses that arrive while the block is busy, and the stimulus sends such a pulse on purpose. The bench pulses each request for one clock from the idle state. It drives `bus_ready` from a count of strobe clocks, so the memory answers only in data states and after the requested number of wait states. It runs two instances at once, a 16-bit bus without translation and a 32-bit bus with translation, and keeps requests within 8-bit addresses that its byte memory model covers.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_TX   = 3'd2,
        ST_T2   = 3'd3,
        ST_T3   = 3'd4,
        ST_T4   = 3'd5
    } bus_state_e;

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/bus_seq_lane.sv
module bus_seq_lane #(
    parameter int BUS_BYTES = 2,
    parameter int ADDR_W    = 16,
    localparam int BUS_W    = 8 * BUS_BYTES,
    localparam int OFS_W    = $clog2(BUS_BYTES)
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [2:0]        rem,
    input  logic [31:0]       wdata_sh,
    output logic [OFS_W-1:0]  offset,
    output logic [2:0]        nbytes,
    output logic [BUS_BYTES-1:0] be,
    output logic [ADDR_W-1:0] word_addr,
    output logic [BUS_W-1:0]  lane_wdata
);
    logic [2:0]  room;
    logic [31:0] placed;

    always_comb begin
        offset    = cur_addr[OFS_W-1:0];
        room      = 3'(BUS_BYTES) - 3'(offset);
        nbytes    = (rem < room) ? rem : room;
        word_addr = {cur_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        placed    = wdata_sh << {offset, 3'b000};
    end

    for (genvar j = 0; j < BUS_BYTES; j++) begin : g_lane
        assign be[j] = (3'(j) >= 3'(offset)) && (3'(j) < 3'(offset) + nbytes);
        assign lane_wdata[8*j +: 8] = be[j] ? placed[8*j +: 8] : 8'h00;
    end

endmodule

// File: rtl/bus_seq_merge.sv
module bus_seq_merge #(
    parameter int BUS_BYTES = 2,
    localparam int BUS_W    = 8 * BUS_BYTES,
    localparam int OFS_W    = $clog2(BUS_BYTES)
) (
    input  logic [31:0]      op_in,
    input  logic [BUS_W-1:0] rdata,
    input  logic [OFS_W-1:0] offset,
    input  logic [2:0]       nbytes,
    input  logic [2:0]       done,
    output logic [31:0]      op_out
);
    logic [31:0] lanes;
    logic [31:0] mask;

    for (genvar i = 0; i < 4; i++) begin : g_mask
        assign mask[8*i +: 8] = (3'(i) < nbytes) ? 8'hFF : 8'h00;
    end

    always_comb begin
        lanes  = 32'(rdata) >> {offset, 3'b000};
        op_out = op_in | ((lanes & mask) << {done, 3'b000});
    end

endmodule

// File: rtl/bus_seq.sv
module bus_seq
    import bus_seq_pkg::*;
#(
    parameter int BUS_BYTES = 2,
    parameter bit XLAT      = 1'b0,
    parameter int ADDR_W    = 16,
    localparam int BUS_W    = 8 * BUS_BYTES,
    localparam int OFS_W    = $clog2(BUS_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_size,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_write,
    input  logic [31:0]          req_wdata,
    input  logic                 bus_ready,
    input  logic [BUS_W-1:0]     bus_rdata,
    output logic                 busy,
    output logic                 op_ready,
    output logic [31:0]          op_rdata,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic                 bus_as,
    output logic                 bus_rd,
    output logic                 bus_wr,
    output logic [BUS_BYTES-1:0] bus_be,
    output logic [BUS_W-1:0]     bus_wdata
);

    typedef struct packed {
        bus_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        rem;
        logic [2:0]        done;
        logic [31:0]       wdata;
        logic [31:0]       op;
        logic              write;
        logic              rdy;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st: ST_IDLE, addr: '0, rem: 3'd0, done: 3'd0,
        wdata: 32'h0, op: 32'h0, write: 1'b0, rdy: 1'b0
    };

    seq_t s_q, s_d;

    logic [OFS_W-1:0]     offset;
    logic [2:0]           nbytes;
    logic [BUS_BYTES-1:0] lane_be;
    logic [ADDR_W-1:0]    word_addr;
    logic [BUS_W-1:0]     lane_wdata;
    logic [31:0]          merged;
    logic                 last_cycle;

    bus_seq_lane #(.BUS_BYTES(BUS_BYTES), .ADDR_W(ADDR_W)) u_lane (
        .cur_addr   (s_q.addr),
        .rem        (s_q.rem),
        .wdata_sh   (s_q.wdata),
        .offset     (offset),
        .nbytes     (nbytes),
        .be         (lane_be),
        .word_addr  (word_addr),
        .lane_wdata (lane_wdata)
    );

    bus_seq_merge #(.BUS_BYTES(BUS_BYTES)) u_merge (
        .op_in  (s_q.op),
        .rdata  (bus_rdata),
        .offset (offset),
        .nbytes (nbytes),
        .done   (s_q.done),
        .op_out (merged)
    );

    assign last_cycle = (nbytes == s_q.rem);

    always_comb begin
        s_d     = s_q;
        s_d.rdy = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st    = ST_T1;
                    s_d.addr  = req_addr;
                    s_d.rem   = size_bytes(req_size);
                    s_d.done  = 3'd0;
                    s_d.wdata = req_wdata;
                    s_d.op    = 32'h0;
                    s_d.write = req_write;
                end
            end
            ST_T1: s_d.st = XLAT ? ST_TX : ST_T2;
            ST_TX: s_d.st = ST_T2;
            ST_T2: s_d.st = ST_T3;
            ST_T3: begin
                if (bus_ready) begin
                    s_d.st  = ST_T4;
                    s_d.rdy = last_cycle;
                    if (!s_q.write) begin
                        s_d.op = merged;
                    end
                end
            end
            ST_T4: begin
                if (last_cycle) begin
                    s_d.st  = ST_IDLE;
                    s_d.rem = 3'd0;
                end else begin
                    s_d.st    = ST_T1;
                    s_d.addr  = s_q.addr + ADDR_W'(nbytes);
                    s_d.rem   = s_q.rem - nbytes;
                    s_d.done  = s_q.done + nbytes;
                    s_d.wdata = s_q.wdata >> {nbytes, 3'b000};
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= SEQ_RST;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        busy      = (s_q.st != ST_IDLE);
        op_ready  = s_q.rdy;
        op_rdata  = s_q.op;
        bus_as    = (s_q.st == ST_T1);
        bus_rd    = !s_q.write && ((s_q.st == ST_T2) || (s_q.st == ST_T3));
        bus_wr    =  s_q.write && ((s_q.st == ST_T2) || (s_q.st == ST_T3));
        bus_addr  = busy ? word_addr : '0;
        bus_be    = busy ? lane_be : '0;
        bus_wdata = (busy && s_q.write) ? lane_wdata : '0;
    end

endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk #(
    parameter int BUS_BYTES = 2,
    parameter int ADDR_W    = 16,
    localparam int OFS_W    = $clog2(BUS_BYTES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 busy,
    input logic                 op_ready,
    input logic                 bus_as,
    input logic                 bus_rd,
    input logic                 bus_wr,
    input logic [BUS_BYTES-1:0] bus_be,
    input logic [ADDR_W-1:0]    bus_addr
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_be == '0) && !bus_as && !bus_rd && !bus_wr && !op_ready); // R1

    AST_AS_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as |=> !bus_as); // R2

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr) && !(bus_as && (bus_rd || bus_wr))); // R2

    AST_READY_IN_WINDDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        op_ready |-> busy && !bus_rd && !bus_wr && !bus_as); // R5

    AST_READY_ENDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        op_ready |=> !busy && !op_ready); // R5

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as |-> (bus_be != '0) && (bus_addr[OFS_W-1:0] == '0)); // R7

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bus_as && $past(busy)) |-> ($stable(bus_addr) && $stable(bus_be))); // R7

    AST_ACCEPT_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid)); // R10

endmodule

bind bus_seq bus_seq_chk #(.BUS_BYTES(BUS_BYTES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .op_ready  (op_ready),
    .bus_as    (bus_as),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_be    (bus_be),
    .bus_addr  (bus_addr)
);

// File: tb/bus_seq_bench.sv
`timescale 1ns/1ps
module bus_seq_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid_a = 1'b0, req_valid_b = 1'b0;
    logic [1:0]  req_size  = 2'd0;
    logic [15:0] req_addr  = 16'h0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = 32'h0;
    logic        bus_ready;

    logic        busy_a, op_ready_a, as_a, rd_a, wr_a;
    logic [31:0] op_rdata_a;
    logic [15:0] addr_a;
    logic [1:0]  be_a;
    logic [15:0] wd_a, rdata_a;

    logic        busy_b, op_ready_b, as_b, rd_b, wr_b;
    logic [31:0] op_rdata_b;
    logic [15:0] addr_b;
    logic [3:0]  be_b;
    logic [31:0] wd_b, rdata_b;

    bus_seq #(.BUS_BYTES(2), .XLAT(1'b0), .ADDR_W(16)) u_bus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid_a), .req_size(req_size),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .bus_ready(bus_ready), .bus_rdata(rdata_a), .busy(busy_a),
        .op_ready(op_ready_a), .op_rdata(op_rdata_a), .bus_addr(addr_a),
        .bus_as(as_a), .bus_rd(rd_a), .bus_wr(wr_a), .bus_be(be_a), .bus_wdata(wd_a)
    );

    bus_seq #(.BUS_BYTES(4), .XLAT(1'b1), .ADDR_W(16)) u_bus_seq_w (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid_b), .req_size(req_size),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .bus_ready(bus_ready), .bus_rdata(rdata_b), .busy(busy_b),
        .op_ready(op_ready_b), .op_rdata(op_rdata_b), .bus_addr(addr_b),
        .bus_as(as_b), .bus_rd(rd_b), .bus_wr(wr_b), .bus_be(be_b), .bus_wdata(wd_b)
    );

    // byte memory model shared by both instances
    logic [7:0] mem [0:255];
    logic [7:0] exp_mem [0:255];
    logic       mem_load = 1'b1;

    function automatic logic [7:0] pattern(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    always_comb begin
        for (int j = 0; j < 2; j++) rdata_a[8*j +: 8] = mem[8'(addr_a[7:0] + 8'(j))];
        for (int j = 0; j < 4; j++) rdata_b[8*j +: 8] = mem[8'(addr_b[7:0] + 8'(j))];
    end

    always @(posedge clk) begin
        if (mem_load) begin
            for (int i = 0; i < 256; i++) mem[i] <= pattern(i);
        end else begin
            if (wr_a && bus_ready)
                for (int j = 0; j < 2; j++)
                    if (be_a[j]) mem[8'(addr_a[7:0] + 8'(j))] <= wd_a[8*j +: 8];
            if (wr_b && bus_ready)
                for (int j = 0; j < 4; j++)
                    if (be_b[j]) mem[8'(addr_b[7:0] + 8'(j))] <= wd_b[8*j +: 8];
        end
    end

    // memory ready: answers after the requested wait states in each data state
    logic sel = 1'b0;
    int   waits = 0;
    int   strb_cnt = 0;
    logic strobe_s, busy_s, op_ready_s, as_s;
    logic [31:0] op_rdata_s;
    logic [3:0]  be_s;

    assign strobe_s   = sel ? (rd_b | wr_b) : (rd_a | wr_a);
    assign busy_s     = sel ? busy_b : busy_a;
    assign op_ready_s = sel ? op_ready_b : op_ready_a;
    assign as_s       = sel ? as_b : as_a;
    assign op_rdata_s = sel ? op_rdata_b : op_rdata_a;
    assign be_s       = sel ? be_b : {2'b00, be_a};
    assign bus_ready  = (strb_cnt >= 1 + waits);

    always @(posedge clk) strb_cnt <= strobe_s ? strb_cnt + 1 : 0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic       sel;
        logic [1:0] size;
        logic [7:0] addr;
        logic       wr;
        logic [3:0] waits;
        logic [7:0] lat;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b0, 2'd0, 8'h11, 1'b0, 4'd0, 8'd3},
        '{1'b0, 2'd1, 8'h20, 1'b0, 4'd0, 8'd3},
        '{1'b0, 2'd1, 8'h21, 1'b0, 4'd0, 8'd7},
        '{1'b0, 2'd2, 8'h40, 1'b0, 4'd0, 8'd7},
        '{1'b0, 2'd2, 8'h43, 1'b0, 4'd0, 8'd11},
        '{1'b0, 2'd3, 8'h42, 1'b0, 4'd0, 8'd7},
        '{1'b0, 2'd1, 8'h31, 1'b1, 4'd0, 8'd7},
        '{1'b0, 2'd2, 8'h51, 1'b1, 4'd0, 8'd11},
        '{1'b0, 2'd1, 8'h60, 1'b0, 4'd2, 8'd5},
        '{1'b1, 2'd0, 8'h13, 1'b0, 4'd0, 8'd4},
        '{1'b1, 2'd1, 8'h21, 1'b0, 4'd0, 8'd4},
        '{1'b1, 2'd1, 8'h23, 1'b0, 4'd0, 8'd9},
        '{1'b1, 2'd2, 8'h40, 1'b0, 4'd0, 8'd4},
        '{1'b1, 2'd2, 8'h42, 1'b0, 4'd0, 8'd9},
        '{1'b1, 2'd2, 8'h47, 1'b1, 4'd0, 8'd9},
        '{1'b1, 2'd2, 8'h45, 1'b0, 4'd1, 8'd11}
    };

    task automatic run(input vec_t v, input logic [31:0] wdata, input bit intrude);
        int nb, bb, ncyc, off, n1, lat, ascnt, stcnt;
        logic [31:0] exp_rd;
        logic [3:0]  exp_be;
        bit ok;
        string ctag;
        nb    = (v.size == 2'd0) ? 1 : (v.size == 2'd1) ? 2 : 4;
        bb    = v.sel ? 4 : 2;
        ncyc  = ((int'(v.addr) + nb - 1) / bb) - (int'(v.addr) / bb) + 1;
        off   = int'(v.addr) % bb;
        n1    = (nb < bb - off) ? nb : bb - off;
        exp_be = 4'(((1 << n1) - 1) << off);
        ctag  = v.sel ? "R4 cycles" : "R3 cycles";
        @(negedge clk);
        sel = v.sel; waits = int'(v.waits);
        req_size = v.size; req_addr = {8'h00, v.addr}; req_write = v.wr; req_wdata = wdata;
        if (v.sel) req_valid_b = 1'b1; else req_valid_a = 1'b1;
        @(negedge clk);
        req_valid_a = 1'b0; req_valid_b = 1'b0;
        chk(busy_s == 1'b1, "R10 accepted when idle", 32'(busy_s), 32'h1);
        chk(be_s == exp_be, "R7 first byte enables", 32'(be_s), 32'(exp_be));
        lat = 0; ascnt = as_s ? 1 : 0; stcnt = strobe_s ? 1 : 0;
        while (!op_ready_s && lat < 200) begin
            @(negedge clk);
            lat++;
            if (intrude && lat == 1) begin
                req_write = 1'b1; req_addr = 16'h0010; req_size = 2'd2;
                if (v.sel) req_valid_b = 1'b1; else req_valid_a = 1'b1;
            end
            if (intrude && lat == 2) begin
                req_valid_a = 1'b0; req_valid_b = 1'b0;
            end
            if (as_s) ascnt++;
            if (strobe_s) stcnt++;
        end
        chk(lat == int'(v.lat), (v.waits != 0) ? "R6 latency with waits" : "R5 latency",
            32'(lat), 32'(v.lat));
        chk(ascnt == ncyc, ctag, 32'(ascnt), 32'(ncyc));
        chk(stcnt == ncyc * (2 + int'(v.waits)), "R2 strobe clocks",
            32'(stcnt), 32'(ncyc * (2 + int'(v.waits))));
        if (!v.wr) begin
            exp_rd = 32'h0;
            for (int i = 0; i < nb; i++) exp_rd[8*i +: 8] = exp_mem[8'(v.addr + 8'(i))];
            chk(op_rdata_s == exp_rd, "R8 read assembly", op_rdata_s, exp_rd);
        end
        @(negedge clk);
        chk(busy_s == 1'b0 && op_ready_s == 1'b0, "R5 busy ends after ready",
            {busy_s, op_ready_s}, 32'h0);
        if (v.wr) begin
            for (int i = 0; i < nb; i++) exp_mem[8'(v.addr + 8'(i))] = wdata[8*i +: 8];
            ok = 1'b1;
            for (int i = -2; i < 6; i++)
                if (mem[8'(int'(v.addr) + i)] !== exp_mem[8'(int'(v.addr) + i)]) ok = 1'b0;
            chk(ok, "R9 write bytes and neighbours", 32'(ok), 32'h1);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) exp_mem[i] = pattern(i);
        repeat (3) @(negedge clk);
        chk(!busy_a && !op_ready_a && !as_a && !rd_a && !wr_a && be_a == 2'b00,
            "R1 reset quiet 16-bit", {busy_a, op_ready_a, as_a, rd_a, wr_a, 2'b00, be_a}, 32'h0);
        chk(!busy_b && !op_ready_b && !as_b && !rd_b && !wr_b && be_b == 4'b0000,
            "R1 reset quiet 32-bit", {busy_b, op_ready_b, as_b, rd_b, wr_b, be_b}, 32'h0);
        rst_n = 1'b1;
        mem_load = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy_a && !busy_b && be_a == 2'b00 && be_b == 4'b0000,
            "R1 idle after reset", {busy_a, busy_b, be_a, be_b}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            run(VEC[k], 32'hA1B2C3D4 ^ 32'(k * 32'h01010101), 1'b0);
        end

        // request pulse while busy is dropped
        run('{1'b0, 2'd2, 8'h43, 1'b0, 4'd0, 8'd11}, 32'h0, 1'b1);
        begin
            bit idle_ok;
            idle_ok = 1'b1;
            repeat (8) begin
                @(negedge clk);
                if (busy_a) idle_ok = 1'b0;
            end
            chk(idle_ok, "R10 dropped request never starts", 32'(idle_ok), 32'h1);
            chk(mem[8'h10] == exp_mem[8'h10] && mem[8'h13] == exp_mem[8'h13],
                "R10 dropped write left memory", {24'h0, mem[8'h10]}, {24'h0, exp_mem[8'h10]});
        end

        run('{1'b1, 2'd2, 8'h43, 1'b0, 4'd0, 8'd9}, 32'h0, 1'b1);
        chk(mem[8'h10] == exp_mem[8'h10], "R10 dropped write left memory 32-bit",
            {24'h0, mem[8'h10]}, {24'h0, exp_mem[8'h10]});

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule